// File: doc/BRIEF.md
# Routed Level Interrupt Aggregator

This block collects a set of level-sensitive interrupt sources, arranged in 32-bit words, and drives a small number of upstream interrupt lines. Each word has an enable register and a read-only status view. Every upstream line has its own routing mask for each word. A line asserts whenever some source is high, enabled and routed to that line. The same set of sources can therefore be split across several upstream handlers, or duplicated onto them.

A low-power input widens the enables while it is high. During that time, each word's enable is ORed with a per-word wake register, so that chosen sources can still raise an upstream line during suspend. Nothing is latched: a status bit simply mirrors its input. An upstream line falls again only once the source drops or is masked.

Software reaches the registers through a plain single-cycle bus. A write is a strobe with an address and data. Read data is a combinational function of the address.

With the default parameters (4 words, 2 outputs) the register layout is as follows:
- **Per-word pairs**, at byte addresses 0x00 to 0x1C. Each word takes 8 bytes: the enable comes first and the status second.
- **Routing masks**, at 0x20 to 0x3C.
- **Wake registers**, at 0x40 to 0x4C.

Top module: `irq_aggregator`

## Requirements
- R1: After reset every enable, routing and wake register reads 0, and every upstream output is low.
- R2: The enable register of word w sits at byte address 8*w. It reads back what was written. Bit b set to 1 unmasks source 32*w+b, and 0 masks it.
- R3: Byte address 8*w+4 returns the raw levels of word w's sources, unmasked. A write to that address changes no register.
- R4: Upstream output o is high one clock after the AND of source level, effective enable and output o's routing mask becomes nonzero in any word. It is low one clock after that AND is zero in every word. A source change is never visible at the output before the next rising clock.
- R5: The routing mask for output o and word w sits at byte address 8*NWORDS + 4*(o*NWORDS + w), in output-major order, and reads back what was written.
- R6: A source whose bit is clear in every output's routing mask never raises any output, whatever its enable and level.
- R7: While suspend is 1, the effective enable of word w is its enable ORed with its wake register. The wake register sits at byte address 8*NWORDS + 4*NOUT*NWORDS + 4*w.
- R8: While suspend is 0, the wake registers have no effect on any output.
- R9: A misaligned byte address (low two bits nonzero), or one beyond the last wake register, reads 0. A write to such an address changes no register.
- R10: Each output follows only its own routing masks. A source routed to one output does not raise another.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to clk |
| suspend | input | 1 | Low-power mode; ORs the wake registers into the enables |
| src_lvl | input | NWORDS*32 | Level interrupt sources, word w at bits [32*w+31:32*w] |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_addr | input | AW | Byte address for both reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_out | output | NOUT | Registered upstream interrupt lines |

## Verification
The assertions take the source levels and the suspend input to be synchronous to clk and stable around each rising edge. Under that assumption, the value sampled one cycle back describes what the output register captured. The bench meets this assumption by changing every input only on the falling edge.

Random stimulus mixes three kinds of change, each applied at that edge:
- writes to any address, including status, misaligned and unmapped addresses;
- sparse random source patterns;
- toggles of suspend.

The directed cases cover the single-cycle latency, routing that sends a source to one output only, sources that no mask routes, and the wake-only path.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

  localparam int unsigned WORD_BITS = 32;

  // Register classes reached through the address decoder
  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_EN,
    SEL_ST,
    SEL_RT,
    SEL_WK
  } reg_sel_e;

  typedef struct packed {
    reg_sel_e   sel;
    logic [7:0] slot;
  } reg_dec_t;

endpackage

// File: rtl/irq_agg_regs.sv
module irq_agg_regs
  import irq_agg_pkg::*;
#(
  parameter int unsigned NWORDS = 4,
  parameter int unsigned NOUT   = 2,
  parameter int unsigned AW     = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           bus_wr,
  input  logic [AW-1:0]                  bus_addr,
  input  logic [WORD_BITS-1:0]           bus_wdata,
  output logic [WORD_BITS-1:0]           bus_rdata,
  input  logic [NWORDS*WORD_BITS-1:0]    src_lvl,
  output logic [NWORDS*WORD_BITS-1:0]    en_flat,
  output logic [NWORDS*WORD_BITS-1:0]    wk_flat,
  output logic [NOUT*NWORDS*WORD_BITS-1:0] rt_flat
);

  localparam int unsigned NRT     = NOUT * NWORDS;
  localparam int unsigned RT_BASE = 2 * NWORDS;
  localparam int unsigned WK_BASE = RT_BASE + NRT;
  localparam int unsigned LIMIT   = WK_BASE + NWORDS;

  reg_dec_t    dec;
  int unsigned idx;

  // Address decode: word index, then register class and slot
  always_comb begin
    idx      = 32'(bus_addr[AW-1:2]);
    dec.sel  = SEL_NONE;
    dec.slot = '0;
    if (bus_addr[1:0] == 2'b00) begin
      if (idx < RT_BASE) begin
        dec.sel  = idx[0] ? SEL_ST : SEL_EN;
        dec.slot = 8'(idx >> 1);
      end else if (idx < WK_BASE) begin
        dec.sel  = SEL_RT;
        dec.slot = 8'(idx - RT_BASE);
      end else if (idx < LIMIT) begin
        dec.sel  = SEL_WK;
        dec.slot = 8'(idx - WK_BASE);
      end
    end
  end

  logic [WORD_BITS-1:0] en_q [NWORDS];
  logic [WORD_BITS-1:0] wk_q [NWORDS];
  logic [WORD_BITS-1:0] rt_q [NRT];

  for (genvar w = 0; w < NWORDS; w++) begin : g_word
    logic                 en_we, wk_we;
    logic [WORD_BITS-1:0] en_d, wk_d;

    always_comb begin
      en_we = bus_wr && (dec.sel == SEL_EN) && (dec.slot == 8'(w));
      wk_we = bus_wr && (dec.sel == SEL_WK) && (dec.slot == 8'(w));
      en_d  = en_we ? bus_wdata : en_q[w];
      wk_d  = wk_we ? bus_wdata : wk_q[w];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        en_q[w] <= '0;
        wk_q[w] <= '0;
      end else begin
        en_q[w] <= en_d;
        wk_q[w] <= wk_d;
      end
    end

    assign en_flat[w*WORD_BITS +: WORD_BITS] = en_q[w];
    assign wk_flat[w*WORD_BITS +: WORD_BITS] = wk_q[w];
  end

  for (genvar r = 0; r < NRT; r++) begin : g_route
    logic                 rt_we;
    logic [WORD_BITS-1:0] rt_d;

    always_comb begin
      rt_we = bus_wr && (dec.sel == SEL_RT) && (dec.slot == 8'(r));
      rt_d  = rt_we ? bus_wdata : rt_q[r];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rt_q[r] <= '0;
      else        rt_q[r] <= rt_d;
    end

    assign rt_flat[r*WORD_BITS +: WORD_BITS] = rt_q[r];
  end

  // Read mux
  always_comb begin
    bus_rdata = '0;
    unique case (dec.sel)
      SEL_EN: for (int w = 0; w < NWORDS; w++)
                if (dec.slot == 8'(w)) bus_rdata = en_q[w];
      SEL_ST: for (int w = 0; w < NWORDS; w++)
                if (dec.slot == 8'(w)) bus_rdata = src_lvl[w*WORD_BITS +: WORD_BITS];
      SEL_WK: for (int w = 0; w < NWORDS; w++)
                if (dec.slot == 8'(w)) bus_rdata = wk_q[w];
      SEL_RT: for (int r = 0; r < NRT; r++)
                if (dec.slot == 8'(r)) bus_rdata = rt_q[r];
      default: bus_rdata = '0;
    endcase
  end

  // R3: status address is read-only
  assert_status_write_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && dec.sel == SEL_ST) |=> $stable({en_flat, wk_flat, rt_flat}));

  // R9: unmapped or misaligned writes leave all state alone
  assert_unmapped_write_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && dec.sel == SEL_NONE) |=> $stable({en_flat, wk_flat, rt_flat}));

endmodule

// File: rtl/irq_agg_combine.sv
module irq_agg_combine
  import irq_agg_pkg::*;
#(
  parameter int unsigned NWORDS = 4,
  parameter int unsigned NOUT   = 2
) (
  input  logic                             suspend,
  input  logic [NWORDS*WORD_BITS-1:0]      src_lvl,
  input  logic [NWORDS*WORD_BITS-1:0]      en_flat,
  input  logic [NWORDS*WORD_BITS-1:0]      wk_flat,
  input  logic [NOUT*NWORDS*WORD_BITS-1:0] rt_flat,
  output logic [NOUT-1:0]                  hit
);

  localparam int unsigned SET_BITS = NWORDS * WORD_BITS;

  logic [SET_BITS-1:0] eff_en;
  logic [SET_BITS-1:0] live;

  // Wake merge: the wake registers only widen the enables in suspend
  always_comb begin
    eff_en = suspend ? (en_flat | wk_flat) : en_flat;
    live   = src_lvl & eff_en;
  end

  // Each output owns a contiguous block of NWORDS routing words
  for (genvar o = 0; o < NOUT; o++) begin : g_out
    assign hit[o] = |(live & rt_flat[o*SET_BITS +: SET_BITS]);
  end

endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_agg_pkg::*;
#(
  parameter int unsigned NWORDS = 4,
  parameter int unsigned NOUT   = 2,
  parameter int unsigned AW     = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        suspend,
  input  logic [NWORDS*WORD_BITS-1:0] src_lvl,
  input  logic                        bus_wr,
  input  logic [AW-1:0]               bus_addr,
  input  logic [WORD_BITS-1:0]        bus_wdata,
  output logic [WORD_BITS-1:0]        bus_rdata,
  output logic [NOUT-1:0]             irq_out
);

  localparam int unsigned SET_BITS = NWORDS * WORD_BITS;

  logic [SET_BITS-1:0]      en_flat;
  logic [SET_BITS-1:0]      wk_flat;
  logic [NOUT*SET_BITS-1:0] rt_flat;
  logic [NOUT-1:0]          hit;
  logic [NOUT-1:0]          irq_d;
  logic [NOUT-1:0]          irq_q;

  irq_agg_regs #(.NWORDS(NWORDS), .NOUT(NOUT), .AW(AW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .src_lvl   (src_lvl),
    .en_flat   (en_flat),
    .wk_flat   (wk_flat),
    .rt_flat   (rt_flat)
  );

  irq_agg_combine #(.NWORDS(NWORDS), .NOUT(NOUT)) u_combine (
    .suspend (suspend),
    .src_lvl (src_lvl),
    .en_flat (en_flat),
    .wk_flat (wk_flat),
    .rt_flat (rt_flat),
    .hit     (hit)
  );

  // Output register: one cycle from qualifying condition to pin
  always_comb irq_d = hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= '0;
    else        irq_q <= irq_d;
  end

  assign irq_out = irq_q;

  // Union of all routing masks, for the checks below
  logic [SET_BITS-1:0] used_mask;
  always_comb begin
    used_mask = '0;
    for (int o = 0; o < NOUT; o++)
      used_mask = used_mask | rt_flat[o*SET_BITS +: SET_BITS];
  end

  // R6: sources routed nowhere cannot raise an output
  assert_unrouted_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past((src_lvl & used_mask) == '0) |-> (irq_out == '0));

  // R8: outside suspend only the plain enables qualify a source
  assert_wake_inert_awake_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!suspend && ((src_lvl & en_flat) == '0)) |-> (irq_out == '0));

  // R7: in suspend nothing outside enable-or-wake can raise an output
  assert_suspend_scope_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(suspend && ((src_lvl & (en_flat | wk_flat)) == '0)) |-> (irq_out == '0));

endmodule

// File: tb/irq_aggregator_test.sv
module irq_aggregator_test;

  localparam int NW   = 4;
  localparam int NOUT = 2;
  localparam int AW   = 8;
  localparam int NB   = NW * 32;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            susp;
  logic [NB-1:0]   src;
  logic            wr;
  logic [AW-1:0]   addr;
  logic [31:0]     wdata;
  logic [31:0]     rdata;
  logic [NOUT-1:0] irq_out;

  int errs  = 0;
  int total = 0;

  logic [31:0] m_en [NW];
  logic [31:0] m_wk [NW];
  logic [31:0] m_rt [NOUT*NW];

  always #10 clk = ~clk;

  irq_aggregator #(.NWORDS(NW), .NOUT(NOUT), .AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .suspend(susp), .src_lvl(src),
    .bus_wr(wr), .bus_addr(addr), .bus_wdata(wdata),
    .bus_rdata(rdata), .irq_out(irq_out)
  );

  function automatic logic [NOUT-1:0] exp_out();
    logic [NOUT-1:0] r = '0;
    for (int o = 0; o < NOUT; o++)
      for (int w = 0; w < NW; w++) begin
        logic [31:0] eff = susp ? (m_en[w] | m_wk[w]) : m_en[w];
        if ((src[w*32 +: 32] & eff & m_rt[o*NW+w]) != 0) r[o] = 1'b1;
      end
    return r;
  endfunction

  function automatic logic [31:0] exp_rd(logic [AW-1:0] a);
    int i = int'(a) >> 2;
    if (a[1:0] != 2'b00)       return 32'h0;
    if (i < 2*NW)              return i[0] ? src[(i/2)*32 +: 32] : m_en[i/2];
    if (i < 2*NW + NOUT*NW)    return m_rt[i - 2*NW];
    if (i < 3*NW + NOUT*NW)    return m_wk[i - 2*NW - NOUT*NW];
    return 32'h0;
  endfunction

  task automatic model_write(logic [AW-1:0] a, logic [31:0] d);
    int i = int'(a) >> 2;
    if (a[1:0] != 2'b00) return;
    if (i < 2*NW) begin
      if (!i[0]) m_en[i/2] = d;
    end else if (i < 2*NW + NOUT*NW) m_rt[i - 2*NW] = d;
    else if (i < 3*NW + NOUT*NW)     m_wk[i - 2*NW - NOUT*NW] = d;
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_write(logic [AW-1:0] a, logic [31:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
    model_write(a, d);
  endtask

  task automatic chk_rd(string tag, logic [AW-1:0] a);
    @(negedge clk);
    addr = a;
    #1;
    chk(tag, rdata, exp_rd(a));
  endtask

  task automatic settle_chk(string tag);
    repeat (2) @(negedge clk);
    chk(tag, 32'(irq_out), 32'(exp_out()));
  endtask

  task automatic set_src(logic [NB-1:0] v);
    @(negedge clk);
    src = v;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errs, total);
    $finish;
  endtask

  function automatic logic [AW-1:0] a_en(int w);        return AW'(8*w);                     endfunction
  function automatic logic [AW-1:0] a_st(int w);        return AW'(8*w + 4);                 endfunction
  function automatic logic [AW-1:0] a_rt(int o, int w); return AW'(8*NW + 4*(o*NW + w));      endfunction
  function automatic logic [AW-1:0] a_wk(int w);        return AW'(8*NW + 4*NOUT*NW + 4*w);   endfunction

  initial begin
    repeat (100000) @(posedge clk);
    errs++; total++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int w = 0; w < NW; w++) begin m_en[w] = '0; m_wk[w] = '0; end
    for (int r = 0; r < NOUT*NW; r++) m_rt[r] = '0;
    rst_n = 1'b0; susp = 1'b0; src = '0; wr = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    chk("R1 outputs", 32'(irq_out), 32'h0);
    chk_rd("R1 enable", a_en(2));
    chk_rd("R1 route", a_rt(1, 3));
    chk_rd("R1 wake", a_wk(0));

    // R2: enable readback
    bus_write(a_en(1), 32'hA5A5_0F0F);
    chk_rd("R2 enable readback", a_en(1));
    bus_write(a_en(1), 32'h0);

    // R3: raw status, write ignored
    set_src({NB{1'b0}} | (NB'(32'h1234_8001) << 64));
    chk_rd("R3 raw status", a_st(2));
    bus_write(a_st(2), 32'hFFFF_FFFF);
    chk_rd("R3 status after write", a_st(2));
    chk_rd("R3 enable untouched", a_en(2));
    set_src('0);

    // R4: one-cycle latency
    bus_write(a_en(0), 32'h1);
    bus_write(a_rt(0, 0), 32'h1);
    settle_chk("R4 idle");
    @(negedge clk); src[0] = 1'b1;
    #1 chk("R4 not before edge", 32'(irq_out), 32'h0);
    @(negedge clk);
    chk("R4 rise after one edge", 32'(irq_out), 32'h1);
    src[0] = 1'b0;
    #1 chk("R4 hold before edge", 32'(irq_out), 32'h1);
    @(negedge clk);
    chk("R4 fall after one edge", 32'(irq_out), 32'h0);

    // R5 / R10: route a source to output 1 only
    bus_write(a_en(0), 32'hFFFF_FFFF);
    bus_write(a_rt(1, 0), 32'h20);
    chk_rd("R5 route readback", a_rt(1, 0));
    set_src(NB'(32'h20));
    settle_chk("R10 only output 1");
    chk("R10 output 0 low", 32'(irq_out[0]), 32'h0);

    // R6: enabled source routed nowhere
    set_src(NB'(32'h200));
    settle_chk("R6 unrouted source");
    chk("R6 all low", 32'(irq_out), 32'h0);

    // R7 / R8: wake path on word 3
    set_src(NB'(1) << 127);
    bus_write(a_rt(0, 3), 32'hFFFF_FFFF);
    bus_write(a_wk(3), 32'h8000_0000);
    chk_rd("R7 wake readback", a_wk(3));
    settle_chk("R8 wake inert awake");
    chk("R8 output 0 low", 32'(irq_out[0]), 32'h0);
    @(negedge clk); susp = 1'b1;
    settle_chk("R7 wake in suspend");
    chk("R7 output 0 high", 32'(irq_out[0]), 32'h1);
    @(negedge clk); susp = 1'b0;
    settle_chk("R8 back awake");

    // R9: unmapped and misaligned
    bus_write(AW'(8'h50), 32'hFFFF_FFFF);
    bus_write(AW'(8'h01), 32'hFFFF_FFFF);
    chk_rd("R9 unmapped read", AW'(8'h50));
    chk_rd("R9 misaligned read", AW'(8'h05));
    chk_rd("R9 enable kept", a_en(0));
    settle_chk("R9 outputs kept");

    // Random mix
    for (int it = 0; it < 400; it++) begin
      int op = int'($urandom % 4);
      if (op == 0) begin
        logic [AW-1:0] a = AW'($urandom % 96);
        if ($urandom % 4 != 0) a[1:0] = 2'b00;
        bus_write(a, $urandom & $urandom);
      end else if (op == 1) begin
        logic [NB-1:0] v;
        for (int w = 0; w < NW; w++) v[w*32 +: 32] = $urandom & $urandom & $urandom;
        set_src(v);
      end else if (op == 2) begin
        @(negedge clk); susp = ~susp;
      end
      settle_chk("R4 random output");
      chk_rd("R5 random read", AW'($urandom % 256));
    end

    finish_run();
  end

endmodule